// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Engine

This block moves data between memory locations on behalf of the processor. It uses the processor's own data bus. It has two independent channels. Each channel keeps base and working copies of a source pointer and a destination pointer, plus a transfer counter and a reload value. The pointer and counter widths are parameters, with defaults of 20 and 16 bits.

A channel becomes pending in either of two ways: software writes its request bit, or the peripheral event picked by its select fields fires. The event path has no masking of its own, and the block never acknowledges or clears the event source. When a channel is enabled and pending, the engine raises a bus request. It waits for the processor's grant and then steals one read cycle followed by one write cycle to move a single byte or word. After that it drops the request and hands the bus back.

Requests that arrive while one is already pending on a channel merge into that pending request. When the counter runs out, a single-mode channel switches itself off. A repeat-mode channel instead reloads its counter and pointers and carries on.

Top module: `cs_dma`

## Requirements
- R1: After reset, bus_req, mem_rd and mem_wr are 0 and every channel is disabled.
- R2: Each transfer reads mem_addr = working source pointer in one cycle (mem_rd=1). The data read is then written in the very next cycle (mem_wr=1) to mem_addr = working destination pointer.
- R3: Control bit 1 selects the unit. At 0, one byte is moved: only mem_rdata[7:0] is used, and a byte write is issued with mem_word=0. At 1, a full 16-bit word is moved with mem_word=1.
- R4: Control bit 3 (source) and control bit 4 (destination) choose per pointer whether it advances after each transfer, by 1 for bytes and by 2 for words, or stays fixed.
- R5: Select register bits [3:0] plus the extension bit 4 form a 5-bit index. Only evt_i[index] raises that channel's request, and all other event bits are ignored.
- R6: Any number of requests that arrive while a channel is already pending produce a single transfer.
- R7: Requests to a channel whose enable (control bit 0) is 0 cause no bus activity.
- R8: In single mode (control bit 2 = 0), a channel loaded with count N performs N transfers and then clears its enable, so further requests are ignored.
- R9: In repeat mode (control bit 2 = 1), the transfer that takes the counter to zero reloads the counter, source pointer and destination pointer from their base values. The channel stays enabled.
- R10: When both channels are pending in the same cycle, channel 0 is transferred first.
- R11: mem_rd and mem_wr are asserted only while bus_req and bus_gnt are both 1. bus_req falls in the cycle after the write.
- R12: Register writes use cfg_reg codes 0 = source base, 1 = destination base, 2 = count, 3 = control and 4 = select. Writing code 0 or 1 also loads the matching working pointer, and writing code 2 also loads the counter. Writing the select register with bit 5 set raises a software request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_reg | input | 3 | Register code within the channel |
| cfg_data | input | 20 | Write data (LSBs used for narrower registers) |
| evt_i | input | 32 | Peripheral event lines, one cycle high per event |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_addr | output | 20 | Byte address of the current access |
| mem_rd | output | 1 | Read strobe, data taken the same cycle |
| mem_wr | output | 1 | Write strobe |
| mem_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |

## Verification
The main copy function runs through every combination of unit size and per-pointer stepping, eight in all. For each combination the bench compares the whole byte-addressed memory against an image built arithmetically. This exposes a wrong byte lane, a wrong step, or a pointer that moves when it should stay fixed. Repeat mode is tested by following the destination address write by write across counter reloads, which shows whether the reload happens on the right transfer. Requests are stacked up while the grant is withheld to separate merging from counting every request. A single event shared by both channels settles priority. Pulses on neighbouring event lines show that the 5-bit select index is decoded exactly.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
   localparam int REG_SEL_W = 3;
   localparam logic [REG_SEL_W-1:0] REG_SRC  = 3'd0;
   localparam logic [REG_SEL_W-1:0] REG_DST  = 3'd1;
   localparam logic [REG_SEL_W-1:0] REG_CNT  = 3'd2;
   localparam logic [REG_SEL_W-1:0] REG_CTL  = 3'd3;
   localparam logic [REG_SEL_W-1:0] REG_SEL  = 3'd4;

   // control register bit positions
   localparam int CTL_EN   = 0;
   localparam int CTL_WORD = 1;
   localparam int CTL_RPT  = 2;
   localparam int CTL_SINC = 3;
   localparam int CTL_DINC = 4;

   // software request bit in the select register
   localparam int SEL_SWREQ = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RD   = 2'd2,
      ST_WR   = 2'd3
   } xfer_st_t;
endpackage

// File: rtl/cs_dma_chan.sv
module cs_dma_chan
   import cs_dma_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int CNT_W      = 16,
   parameter int SEL_W      = 4,
   parameter int WORD_BYTES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_hit,
   input  logic [REG_SEL_W-1:0]        wr_sel,
   input  logic [ADDR_W-1:0]           wr_data,
   input  logic [2**(SEL_W+1)-1:0]     evt_i,
   input  logic                        take,
   input  logic                        done,
   output logic                        pend_o,
   output logic [ADDR_W-1:0]           src_o,
   output logic [ADDR_W-1:0]           dst_o,
   output logic                        word_o
);
   localparam int IDX_W = SEL_W + 1;

   logic [ADDR_W-1:0] src_base, dst_base, src_ptr, dst_ptr;
   logic [CNT_W-1:0]  cnt_rld, cnt;
   logic              en, word, rpt, sinc, dinc;
   logic [IDX_W-1:0]  evt_idx;
   logic              pend_q;
   logic              sw_req, evt_req;
   logic [ADDR_W-1:0] step;

   assign sw_req  = wr_hit && (wr_sel == REG_SEL) && wr_data[SEL_SWREQ];
   assign evt_req = evt_i[evt_idx];
   assign step    = word ? ADDR_W'(WORD_BYTES) : ADDR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= ((pend_q && !take) || sw_req || evt_req) && en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_base <= '0;
         dst_base <= '0;
         src_ptr  <= '0;
         dst_ptr  <= '0;
         cnt_rld  <= '0;
         cnt      <= '0;
         en       <= 1'b0;
         word     <= 1'b0;
         rpt      <= 1'b0;
         sinc     <= 1'b0;
         dinc     <= 1'b0;
         evt_idx  <= '0;
      end else begin
         if (done) begin
            if (cnt == CNT_W'(1)) begin
               if (rpt) begin
                  src_ptr <= src_base;
                  dst_ptr <= dst_base;
                  cnt     <= cnt_rld;
               end else begin
                  if (sinc) src_ptr <= src_ptr + step;
                  if (dinc) dst_ptr <= dst_ptr + step;
                  cnt <= '0;
                  en  <= 1'b0;
               end
            end else begin
               if (sinc) src_ptr <= src_ptr + step;
               if (dinc) dst_ptr <= dst_ptr + step;
               cnt <= cnt - CNT_W'(1);
            end
         end
         if (wr_hit) begin
            case (wr_sel)
               REG_SRC: begin
                  src_base <= wr_data;
                  src_ptr  <= wr_data;
               end
               REG_DST: begin
                  dst_base <= wr_data;
                  dst_ptr  <= wr_data;
               end
               REG_CNT: begin
                  cnt_rld <= wr_data[CNT_W-1:0];
                  cnt     <= wr_data[CNT_W-1:0];
               end
               REG_CTL: begin
                  en   <= wr_data[CTL_EN];
                  word <= wr_data[CTL_WORD];
                  rpt  <= wr_data[CTL_RPT];
                  sinc <= wr_data[CTL_SINC];
                  dinc <= wr_data[CTL_DINC];
               end
               REG_SEL: evt_idx <= wr_data[IDX_W-1:0];
               default: ;
            endcase
         end
      end
   end

   assign pend_o = pend_q && en;
   assign src_o  = src_ptr;
   assign dst_o  = dst_ptr;
   assign word_o = word;
endmodule

// File: rtl/cs_dma_arb.sv
module cs_dma_arb #(
   parameter int NUM_CH = 2,
   parameter int CH_W   = 1
) (
   input  logic [NUM_CH-1:0] pend,
   output logic              any,
   output logic [CH_W-1:0]   win
);
   // lowest index wins
   always_comb begin
      any = |pend;
      win = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (pend[i]) win = CH_W'(i);
      end
   end
endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
   import cs_dma_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CH_W   = 1,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           any,
   input  logic [CH_W-1:0]                win,
   input  logic [NUM_CH-1:0][ADDR_W-1:0]  src,
   input  logic [NUM_CH-1:0][ADDR_W-1:0]  dst,
   input  logic [NUM_CH-1:0]              word,
   output logic [NUM_CH-1:0]              take,
   output logic [NUM_CH-1:0]              done,
   output logic                           bus_req,
   input  logic                           bus_gnt,
   output logic [ADDR_W-1:0]              mem_addr,
   output logic                           mem_rd,
   output logic                           mem_wr,
   output logic                           mem_word,
   output logic [DATA_W-1:0]              mem_wdata,
   input  logic [DATA_W-1:0]              mem_rdata
);
   xfer_st_t          st;
   logic [CH_W-1:0]   cur;
   logic [DATA_W-1:0] latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         cur   <= '0;
         latch <= '0;
      end else begin
         case (st)
            ST_IDLE: if (any) begin
               cur <= win;
               st  <= ST_REQ;
            end
            ST_REQ:  if (bus_gnt) st <= ST_RD;
            ST_RD: begin
               latch <= word[cur] ? mem_rdata
                                  : {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
               st    <= ST_WR;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      take = '0;
      done = '0;
      if (st == ST_IDLE && any) take[win] = 1'b1;
      if (st == ST_WR)          done[cur] = 1'b1;
   end

   assign bus_req   = (st != ST_IDLE);
   assign mem_rd    = (st == ST_RD);
   assign mem_wr    = (st == ST_WR);
   assign mem_addr  = (st == ST_RD) ? src[cur] : dst[cur];
   assign mem_word  = word[cur];
   assign mem_wdata = latch;
endmodule

// File: rtl/cs_dma.sv
module cs_dma
   import cs_dma_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int EVT_N = 2 ** (SEL_W + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CH_W-1:0]      cfg_ch,
   input  logic [REG_SEL_W-1:0] cfg_reg,
   input  logic [ADDR_W-1:0]    cfg_data,
   input  logic [EVT_N-1:0]     evt_i,
   output logic                 bus_req,
   input  logic                 bus_gnt,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic                 mem_word,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata
);
   localparam int WORD_BYTES = DATA_W / 8;

   if (NUM_CH < 2)               $error("cs_dma: NUM_CH must be at least 2");
   if (ADDR_W < CNT_W)           $error("cs_dma: ADDR_W must cover CNT_W");
   if (ADDR_W < SEL_SWREQ + 1)   $error("cs_dma: ADDR_W too small for select");
   if (SEL_W + 1 > SEL_SWREQ)    $error("cs_dma: SEL_W overlaps request bit");
   if (DATA_W < 16 || DATA_W % 8 != 0) $error("cs_dma: DATA_W must be bytes, >= 16");

   logic [NUM_CH-1:0]             pend, take, done, word;
   logic [NUM_CH-1:0][ADDR_W-1:0] src, dst;
   logic                          any;
   logic [CH_W-1:0]               win;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cs_dma_chan #(
         .ADDR_W    (ADDR_W),
         .CNT_W     (CNT_W),
         .SEL_W     (SEL_W),
         .WORD_BYTES(WORD_BYTES)
      ) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (cfg_wr && (cfg_ch == CH_W'(c))),
         .wr_sel (cfg_reg),
         .wr_data(cfg_data),
         .evt_i  (evt_i),
         .take   (take[c]),
         .done   (done[c]),
         .pend_o (pend[c]),
         .src_o  (src[c]),
         .dst_o  (dst[c]),
         .word_o (word[c])
      );
   end

   cs_dma_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
      .pend(pend),
      .any (any),
      .win (win)
   );

   cs_dma_engine #(
      .NUM_CH(NUM_CH),
      .CH_W  (CH_W),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .any      (any),
      .win      (win),
      .src      (src),
      .dst      (dst),
      .word     (word),
      .take     (take),
      .done     (done),
      .bus_req  (bus_req),
      .bus_gnt  (bus_gnt),
      .mem_addr (mem_addr),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .mem_word (mem_word),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );
endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_req,
   input logic bus_gnt,
   input logic mem_rd,
   input logic mem_wr
);
   assert_access_granted_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

   assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> mem_wr);

   assert_write_has_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd));

   assert_bus_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !bus_req);
endmodule

bind cs_dma cs_dma_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .bus_req(bus_req),
   .bus_gnt(bus_gnt),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr)
);

// File: tb/test_cs_dma.sv
module test_cs_dma;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [0:0]  cfg_ch = '0;
   logic [2:0]  cfg_reg = '0;
   logic [19:0] cfg_data = '0;
   logic [31:0] evt = '0;
   logic        bus_req, bus_gnt = 1'b1;
   logic [19:0] mem_addr;
   logic        mem_rd, mem_wr, mem_word;
   logic [15:0] mem_wdata, mem_rdata;

   logic [7:0]  mem   [256];
   logic [7:0]  exp_m [256];
   logic [19:0] wlog  [64];
   int          wcnt = 0;
   int          n_chk = 0, n_bad = 0, cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cs_dma i_cs_dma (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
      .cfg_reg(cfg_reg), .cfg_data(cfg_data), .evt_i(evt),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // byte-addressed little-endian memory model
   assign mem_rdata = {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};

   always @(posedge clk) begin
      if (rst_n && mem_wr) begin
         mem[mem_addr[7:0]] <= mem_wdata[7:0];
         if (mem_word) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
         wlog[wcnt % 64] <= mem_addr;
         wcnt <= wcnt + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [7:0] ib(int a);
      return 8'((a * 13 + 5) & 8'hFF);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wreg(input int ch, input int r, input int d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_ch = 1'(ch); cfg_reg = 3'(r); cfg_data = 20'(d);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic trig(input int ch, input int idx);
      wreg(ch, 4, 32'h20 | idx);
   endtask

   task automatic pulse(input int b);
      @(negedge clk);
      evt[b] = 1'b1;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic init_mem();
      @(negedge clk);
      for (int i = 0; i < 256; i++) begin
         mem[i]   = ib(i);
         exp_m[i] = ib(i);
      end
   endtask

   initial begin
      int base, bad_bytes, step, sa, da;
      for (int i = 0; i < 256; i++) mem[i] = ib(i);
      idle(3);
      // R1: reset state
      chk(!bus_req && !mem_rd && !mem_wr, "R1 reset outputs",
          {bus_req, mem_rd, mem_wr}, 0);
      rst_n = 1'b1;
      idle(2);

      // R7: disabled channel ignores requests (select idx 31, unused event)
      wreg(0, 0, 'h10); wreg(0, 1, 'h80); wreg(0, 2, 3); wreg(0, 3, 0);
      trig(0, 31); idle(10);
      chk(wcnt == 0, "R7 disabled channel no transfer", wcnt, 0);
      chk(!bus_req, "R1 channel disabled after reset", bus_req, 0);

      // R2 R3 R4 R8 R12: sweep of unit size and pointer stepping
      for (int cfg = 0; cfg < 8; cfg++) begin
         step = cfg[0] ? 2 : 1;
         init_mem();
         base = wcnt;
         wreg(0, 0, 'h10); wreg(0, 1, 'h80); wreg(0, 2, 3); wreg(0, 4, 31);
         wreg(0, 3, 1 | (cfg[0] << 1) | (cfg[1] << 3) | (cfg[2] << 4));
         for (int k = 0; k < 3; k++) begin
            sa = 'h10 + (cfg[1] ? k * step : 0);
            da = 'h80 + (cfg[2] ? k * step : 0);
            for (int b = 0; b < step; b++) exp_m[da + b] = ib(sa + b);
            trig(0, 31); idle(8);
         end
         bad_bytes = 0;
         for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) bad_bytes++;
         chk(bad_bytes == 0, $sformatf("R2 R3 R4 R12 copy image cfg=%0d", cfg),
             bad_bytes, 0);
         chk(wcnt - base == 3, "R8 single mode count", wcnt - base, 3);
         trig(0, 31); idle(8);
         chk(wcnt - base == 3, "R8 enable cleared after count", wcnt - base, 3);
      end

      // R5: exact event index decode, index {ext=1, sel=5} = 21
      wreg(0, 0, 'h10); wreg(0, 1, 'h80); wreg(0, 2, 10); wreg(0, 4, 21);
      wreg(0, 3, 1 | (1 << 3) | (1 << 4));
      base = wcnt;
      pulse(20); pulse(22); pulse(5); idle(8);
      chk(wcnt == base, "R5 other event lines ignored", wcnt - base, 0);
      pulse(21); idle(8);
      chk(wcnt - base == 1, "R5 selected event line", wcnt - base, 1);

      // R6 R11: merging while the grant is withheld
      base = wcnt;
      bus_gnt = 1'b0;
      pulse(21); idle(3);
      pulse(21); trig(0, 21); pulse(21); idle(5);
      chk(wcnt == base, "R11 no access without grant", wcnt - base, 0);
      chk(bus_req == 1'b1, "R11 request held while waiting", bus_req, 1);
      bus_gnt = 1'b1;
      idle(15);
      chk(wcnt - base == 2, "R6 merged requests", wcnt - base, 2);
      chk(!bus_req, "R11 bus released", bus_req, 0);
      wreg(0, 3, 0);

      // R9: repeat mode reload, word, both pointers stepping, count 2
      wreg(1, 0, 'h20); wreg(1, 1, 'hA0); wreg(1, 2, 2); wreg(1, 4, 31);
      wreg(1, 3, 1 | 2 | 4 | 8 | 16);
      for (int k = 0; k < 5; k++) begin
         trig(1, 31); idle(8);
         chk(wlog[(wcnt - 1) % 64] == 20'('hA0 + (k % 2) * 2),
             $sformatf("R9 repeat dst addr k=%0d", k),
             int'(wlog[(wcnt - 1) % 64]), 'hA0 + (k % 2) * 2);
      end
      wreg(1, 3, 0);

      // R10: both channels pending in the same cycle
      wreg(0, 0, 'h10); wreg(0, 1, 'h80); wreg(0, 2, 5); wreg(0, 4, 3);
      wreg(0, 3, 1);
      wreg(1, 0, 'h20); wreg(1, 1, 'hC0); wreg(1, 2, 5); wreg(1, 4, 3);
      wreg(1, 3, 1);
      base = wcnt;
      pulse(3); idle(15);
      chk(wcnt - base == 2, "R10 both channels served", wcnt - base, 2);
      chk(wlog[base % 64] == 20'h80, "R10 channel 0 first",
          int'(wlog[base % 64]), 'h80);
      chk(wlog[(base + 1) % 64] == 20'hC0, "R10 channel 1 second",
          int'(wlog[(base + 1) % 64]), 'hC0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule